// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the serial front end for the configuration register of a multi-channel converter. A host acting as bus master lowers an active-low select and toggles a serial clock that idles high. In each frame the host sends a 16-bit command word on the data input, and the block returns a 16-bit result frame on the data output at the same time. The result frame is a 4-bit channel tag followed by a 12-bit sample, both taken from a parallel input port.

The select, serial clock and data input are brought into the system clock domain through a synchronizer chain, and their edges are detected there. The incoming word is collected in a shift register. Once the sixteenth bit is in, the word is decoded into named configuration outputs. Its leading bit is a write strobe that decides whether the rest of the word is applied.

Top module: `sci_ctrl_if`

## Requirements
- R1: The data input is sampled at each falling edge of the serial clock while select is low, and the first bit of the frame is bit 15 of the command word.
- R2: Only the first 16 falling serial clock edges after select goes low are captured. Later falling edges in the same frame change neither the captured word nor the register.
- R3: When bit 15 of a complete word is 1, bits 14..0 are written into the register. When bit 15 is 0, the register keeps its previous value.
- R4: Reset clears every configuration output to 0.
- R5: The word decodes as follows. Bit 14 is repeat mode. Bit (13-i) enables channel i, for i from 0 to 7. Bit 4 is temperature enable, bit 2 is external reference, bit 1 is temperature averaging and bit 0 is partial power-down. Bits 5 and 3 are ignored.
- R6: The result frame is sent MSB first: the 4-bit tag, then the 12-bit sample. Both are latched when select falls. The first bit is driven after select falls, and each later bit after a rising serial clock edge. Once all 16 bits have been sent, the output drives 0.
- R7: Partial power-down stays set through frames that carry no write, and through writes that set bit 0. Only a write with bit 0 at 0 clears it.
- R8: While select is high, the data output is 0 and its output enable is low.
- R9: A frame that ends with fewer than 16 falling edges leaves the register unchanged.
- R10: All fields of the register change together, in the system clock cycle after the sixteenth bit is captured. No partly written value is ever visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial command data |
| res_addr | input | ADDR_W (4) | Channel tag of the result |
| res_data | input | DATA_W (12) | Result sample |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for sdo |
| cfg_repeat | output | 1 | Repeat mode |
| cfg_ch_en | output | 8 | Channel enables, bit i is channel i |
| cfg_temp_en | output | 1 | Temperature conversion enable |
| cfg_ext_ref | output | 1 | External reference select |
| cfg_temp_avg | output | 1 | Temperature averaging enable |
| cfg_pwr_down | output | 1 | Partial power-down |

## Verification
The bench builds the block with the default 4-bit tag and 12-bit sample, and with a three-stage synchronizer. The longer synchronizer shows that the one-cycle load of R10 and the edge timing of R6 do not depend on how many stages the chain has. Each serial half period spans eight system clocks. Every edge therefore reaches the shift registers before the next one, and the bench can watch the register on each cycle after the last bit to catch an intermediate value. The bench also sends frames with extra edges and short frames, which tests the edge counter at both ends.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int NUM_CH     = 8;
  localparam int WR_BIT     = 15;
  localparam int RPT_BIT    = 14;
  localparam int CH0_BIT    = 13;
  localparam int TEMP_BIT   = 4;
  localparam int EXTREF_BIT = 2;
  localparam int AVG_BIT    = 1;
  localparam int PD_BIT     = 0;

  typedef struct packed {
    logic              repeat_en;
    logic [NUM_CH-1:0] ch_en;
    logic              temp_en;
    logic              ext_ref;
    logic              temp_avg;
    logic              pwr_down;
  } cfg_t;

  // Channel i sits at bit (CH0_BIT - i); reserved bits are dropped.
  function automatic cfg_t decode_word(input logic [15:0] w);
    cfg_t c;
    c.repeat_en = w[RPT_BIT];
    for (int i = 0; i < NUM_CH; i++) c.ch_en[i] = w[CH0_BIT - i];
    c.temp_en  = w[TEMP_BIT];
    c.ext_ref  = w[EXTREF_BIT];
    c.temp_avg = w[AVG_BIT];
    c.pwr_down = w[PD_BIT];
    return c;
  endfunction
endpackage

// File: rtl/sci_sync_edge.sv
module sci_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_act,
  output logic cs_fall,
  output logic sclk_fall,
  output logic sclk_rise,
  output logic sdi_s
);
  // bit 2 = cs_n, bit 1 = sclk, bit 0 = sdi; idle value 3'b110
  localparam logic [2:0] IDLE = 3'b110;
  logic [STAGES-1:0][2:0] pipe;
  logic [2:0] last;
  logic [2:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{IDLE}};
      last <= IDLE;
    end else begin
      pipe[0] <= {cs_n, sclk, sdi};
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      last <= pipe[STAGES-1];
    end
  end

  assign cur       = pipe[STAGES-1];
  assign cs_act    = ~cur[2];
  assign cs_fall   = last[2] & ~cur[2];
  assign sclk_fall = last[1] & ~cur[1];
  assign sclk_rise = ~last[1] & cur[1];
  assign sdi_s     = cur[0];
endmodule

// File: rtl/sci_frame_rx.sv
module sci_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_act,
  input  logic               cs_fall,
  input  logic               sclk_fall,
  input  logic               sdi_s,
  output logic [FRAME_W-1:0] word,
  output logic               word_done,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word      <= '0;
      bit_cnt   <= '0;
      word_done <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt   <= '0;
      word_done <= 1'b0;
    end else if (cs_act && sclk_fall && bit_cnt < FULL) begin
      word      <= {word[FRAME_W-2:0], sdi_s};
      bit_cnt   <= bit_cnt + CNT_W'(1);
      word_done <= (bit_cnt == LAST);
    end else begin
      word_done <= 1'b0;
    end
  end
endmodule

// File: rtl/sci_frame_tx.sv
module sci_frame_tx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_act,
  input  logic               cs_fall,
  input  logic               sclk_rise,
  input  logic [FRAME_W-1:0] load_word,
  output logic [FRAME_W-1:0] tx_sh,
  output logic               sdo,
  output logic               sdo_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tx_sh <= '0;
    else if (cs_fall)              tx_sh <= load_word;
    else if (cs_act && sclk_rise)  tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
  end

  assign sdo_oe = cs_act;
  assign sdo    = cs_act & tx_sh[FRAME_W-1];
endmodule

// File: rtl/sci_ctrl_if.sv
module sci_ctrl_if #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic [DATA_W-1:0] res_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              cfg_repeat,
  output logic [7:0]        cfg_ch_en,
  output logic              cfg_temp_en,
  output logic              cfg_ext_ref,
  output logic              cfg_temp_avg,
  output logic              cfg_pwr_down
);
  import sci_pkg::*;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               cs_act, cs_fall, sclk_fall, sclk_rise, sdi_s;
  logic [FRAME_W-1:0] rx_word, tx_sh;
  logic               rx_done;
  logic [CNT_W-1:0]   bit_cnt;
  logic               cfg_load;
  cfg_t               cfg_q;

  sci_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_act(cs_act), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .sclk_rise(sclk_rise), .sdi_s(sdi_s));

  sci_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .word(rx_word),
    .word_done(rx_done), .bit_cnt(bit_cnt));

  sci_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .load_word({res_addr, res_data}),
    .tx_sh(tx_sh), .sdo(sdo), .sdo_oe(sdo_oe));

  assign cfg_load = rx_done & rx_word[WR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= decode_word(rx_word);
  end

  assign cfg_repeat   = cfg_q.repeat_en;
  assign cfg_ch_en    = cfg_q.ch_en;
  assign cfg_temp_en  = cfg_q.temp_en;
  assign cfg_ext_ref  = cfg_q.ext_ref;
  assign cfg_temp_avg = cfg_q.temp_avg;
  assign cfg_pwr_down = cfg_q.pwr_down;
endmodule

// File: rtl/sci_ctrl_if_chk.sv
module sci_ctrl_if_chk #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_act,
  input logic               cs_fall,
  input logic               sclk_rise,
  input logic               rx_done,
  input logic [FRAME_W-1:0] rx_word,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [FRAME_W-1:0] tx_sh,
  input sci_pkg::cfg_t      cfg_q,
  input logic               sdo,
  input logic               sdo_oe
);
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r2_full_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_W'(FRAME_W) && !cs_fall) |=> $stable(rx_word));

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_word[FRAME_W-1]) |=> $stable(cfg_q));

  a_r10_load_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_word[FRAME_W-1]) |=> (cfg_q == sci_pkg::decode_word($past(rx_word))));

  a_r6_shift_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_fall && !sclk_rise) |=> $stable(tx_sh));

  a_r8_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (!sdo && !sdo_oe));

  always @(posedge clk) begin
    if (!rst_n) a_r4_reset_clear: assert (cfg_q == '0);
  end
endmodule

bind sci_ctrl_if sci_ctrl_if_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
  .sclk_rise(sclk_rise), .rx_done(rx_done), .rx_word(rx_word),
  .bit_cnt(bit_cnt), .tx_sh(tx_sh), .cfg_q(cfg_q), .sdo(sdo), .sdo_oe(sdo_oe));

// File: tb/sci_ctrl_if_tb.sv
module sci_ctrl_if_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic [3:0]  res_addr;
  logic [11:0] res_data;
  logic sdo, sdo_oe, cfg_repeat, cfg_temp_en, cfg_ext_ref, cfg_temp_avg, cfg_pwr_down;
  logic [7:0] cfg_ch_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sci_ctrl_if #(.ADDR_W(4), .DATA_W(12), .SYNC_STAGES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .res_addr(res_addr), .res_data(res_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .cfg_repeat(cfg_repeat), .cfg_ch_en(cfg_ch_en), .cfg_temp_en(cfg_temp_en),
    .cfg_ext_ref(cfg_ext_ref), .cfg_temp_avg(cfg_temp_avg), .cfg_pwr_down(cfg_pwr_down));

  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  falls;
    logic [15:0] res;
    logic [14:0] exp_reg;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'hA015, 8'd16, 16'h3ABC, 15'h2015},  // R3 write, R5 ch0+temp+ext+pd
    '{16'h5FFF, 8'd16, 16'h8123, 15'h2015},  // R3 no write
    '{16'hC7C2, 8'd16, 16'hF00F, 15'h47C2},  // R5 repeat, ch3..7, avg
    '{16'h8000, 8'd10, 16'h5A5A, 15'h47C2},  // R9 short frame
    '{16'h8001, 8'd16, 16'h0FFF, 15'h0001},  // R7 pd on
    '{16'h0000, 8'd16, 16'h1000, 15'h0001},  // R7 pd held
    '{16'hBFFF, 8'd20, 16'hC3A5, 15'h3FFF},  // R2 extra edges ignored
    '{16'h8000, 8'd16, 16'h7FFE, 15'h0000}   // R7 pd cleared
  };

  localparam logic [14:0] VIS_MASK = 15'h7FD7;  // bits 5 and 3 not observable

  function automatic logic [14:0] observe();
    logic [14:0] o = '0;
    o[14] = cfg_repeat;
    for (int i = 0; i < 8; i++) o[13-i] = cfg_ch_en[i];
    o[4] = cfg_temp_en;
    o[2] = cfg_ext_ref;
    o[1] = cfg_temp_avg;
    o[0] = cfg_pwr_down;
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] w, input int falls, input logic [15:0] res,
                           input logic [14:0] exp_reg);
    logic [15:0] got = '0;
    logic [15:0] mask;
    logic [14:0] pre, now;
    bit tail_zero = 1, smooth = 1, oe_ok = 1;
    pre = observe();
    {res_addr, res_data} = res;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < falls; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      if (i < 16) got[15-i] = sdo; else if (sdo !== 1'b0) tail_zero = 0;
      if (sdo_oe !== 1'b1) oe_ok = 0;
      sclk = 1'b0;
      if (i == 15 || (falls < 16 && i == falls - 1)) begin
        for (int k = 0; k < HALF; k++) begin
          tick(1);
          now = observe();
          if (now != pre && (now & VIS_MASK) != (exp_reg & VIS_MASK)) smooth = 0;
        end
      end else tick(HALF);
      sclk = 1'b1;
      tick(HALF);
    end
    mask = (falls >= 16) ? 16'hFFFF : ~(16'hFFFF >> falls);
    check(((got ^ res) & mask) == 0, "R6/R1 result frame bits", got & mask, res & mask);
    check(oe_ok, "R8 output enable during frame", oe_ok, 1);
    if (falls > 16) check(tail_zero, "R6 zero after frame", tail_zero, 1);
    check(smooth, "R10 no intermediate register value", smooth, 1);
    cs_n = 1'b1;
    tick(HALF);
    check((observe() & VIS_MASK) == (exp_reg & VIS_MASK), "R3/R5/R7/R9 register",
          observe() & VIS_MASK, exp_reg & VIS_MASK);
    check(sdo === 1'b0 && sdo_oe === 1'b0, "R8 idle output", {sdo, sdo_oe}, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    res_addr = '0; res_data = '0;
    tick(5);
    check(observe() == 0, "R4 reset clears register", observe(), 0);
    check(sdo === 1'b0 && sdo_oe === 1'b0, "R8 idle in reset", {sdo, sdo_oe}, 0);
    rst_n = 1'b1;
    tick(5);

    for (int v = 0; v < 8; v++)
      run_frame(VEC[v].word, int'(VEC[v].falls), VEC[v].res, VEC[v].exp_reg);

    // R5 individual fields with a word setting only temperature and channel 7
    run_frame(16'h8050, 16, 16'hABCD, 15'h0050);
    check(cfg_temp_en === 1'b1 && cfg_ch_en === 8'h80 && cfg_pwr_down === 1'b0,
          "R5 field positions", {cfg_temp_en, cfg_ch_en, cfg_pwr_down}, {1'b1, 8'h80, 1'b0});

    // R9 short frame of one edge, then R4 reset mid-run
    run_frame(16'hFFFF, 1, 16'h8000, 15'h0050);
    run_frame(16'hFFFF, 16, 16'h1234, 15'h7FFF);
    tick(2);
    #1 rst_n = 1'b0;
    tick(2);
    check(observe() == 0, "R4 reset after full write", observe(), 0);
    rst_n = 1'b1;
    tick(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule